// File: doc/BRIEF.md
# Dirty Line Limiter

This block sits beside an L1 data cache and keeps the number of dirty lines in that cache at or below a fixed ceiling. The ceiling comes from the energy a hold-up capacitor can spend on a backup when power fails. The cache reports every write hit with the line's set, way and current dirty flag. The limiter tracks each dirty line in a fully associative table. Each entry holds a valid flag, the set, the way and a saturating write-frequency counter.

A write that turns a clean line dirty needs a table slot. When every slot is taken, the limiter evicts the least frequently written line. It hands that line's set and way to a writeback queue, which cleans the line in the cache, and the freed slot takes the new line. If the queue cannot accept the victim, the limiter asks the pipeline to stall. When a counter would overflow, every counter is aged at once, so their relative order survives.

A backup sequencer walks the table through an indexed read port. The cache drops an entry with an invalidate when it evicts the line.

Top module: `dirty_line_limiter`

## Requirements
- R1: After reset every table entry reads back with rd_valid low, and no write has yet allocated an entry.
- R2: A write hit with hit_dirty low, while a slot is free, raises mark_dirty in the same cycle. From the next cycle the lowest-numbered free entry reads back valid with that set and way, and its counter starts at 1.
- R3: A write hit with hit_dirty high allocates nothing and raises neither mark_dirty nor wbq_push. It adds 1 to the counter of the entry holding that set and way.
- R4: A write hit with hit_dirty low, when all ENTRIES slots are valid and wbq_full is low, raises wbq_push and mark_dirty in the same cycle. wbq_set and wbq_way carry the victim, which is the entry with the smallest counter, taking the lowest index on a tie. From the next cycle the victim's slot holds the new line.
- R5: If that same eviction is needed while wbq_full is high, stall is high and mark_dirty and wbq_push are low in that cycle, and the table does not change.
- R6: A write hit to a tracked dirty line whose counter is already all ones (63 for 6-bit counters) does not wrap. That counter becomes 31, and every other counter loses 32, with results below zero clamped to 0.
- R7: A cycle with neither wr_hit nor inv_req leaves the table unchanged. This covers read hits, which never reach the block.
- R8: inv_req clears the entry whose set and way match inv_set and inv_way. A write hit presented in the same cycle as inv_req is ignored: mark_dirty, wbq_push and stall stay low.
- R9: The read port is combinational. rd_valid, rd_set and rd_way show entry rd_idx as it stands at the start of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hit | input | 1 | L1 write hit this cycle |
| hit_set | input | SET_W | Set index of the written line |
| hit_way | input | WAY_W | Way of the written line |
| hit_dirty | input | 1 | Current dirty flag of the written line |
| inv_req | input | 1 | L1 dropped a line; remove its entry |
| inv_set | input | SET_W | Set of the dropped line |
| inv_way | input | WAY_W | Way of the dropped line |
| mark_dirty | output | 1 | L1 may set the written line's dirty flag |
| stall | output | 1 | Hold the write: the victim cannot be queued |
| wbq_full | input | 1 | Writeback queue cannot accept a push |
| wbq_push | output | 1 | Push victim to the writeback queue |
| wbq_set | output | SET_W | Victim set index |
| wbq_way | output | WAY_W | Victim way |
| rd_idx | input | IDX_W | Entry selected for readout |
| rd_valid | output | 1 | Selected entry is valid |
| rd_set | output | SET_W | Selected entry's set |
| rd_way | output | WAY_W | Selected entry's way |

## Verification
The hardest situation to reach is counter ageing followed by an eviction. One counter has to climb to its maximum while the table is full. The victim then has to be chosen among counters that ageing has clamped to zero and that now tie. The stimulus gets there by filling the table and hammering one tracked line more than 63 times. A clean write then forces an eviction whose victim shows up at the queue port. Earlier, staggered per-line write counts set a known minimum, and a long random phase on a small line space keeps the table full while the queue-full input toggles.

// File: rtl/dirty_line_limiter.sv
module dirty_line_limiter #(
  parameter int ENTRIES = 12,
  parameter int SET_W   = 6,
  parameter int WAY_W   = 2,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             hit_dirty,
  input  logic             inv_req,
  input  logic [SET_W-1:0] inv_set,
  input  logic [WAY_W-1:0] inv_way,
  output logic             mark_dirty,
  output logic             stall,
  input  logic             wbq_full,
  output logic             wbq_push,
  output logic [SET_W-1:0] wbq_set,
  output logic [WAY_W-1:0] wbq_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_way
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HALF    = CNT_W'(1) << (CNT_W - 1);

  logic [ENTRIES-1:0] vld;
  logic [SET_W-1:0]   tset [ENTRIES];
  logic [WAY_W-1:0]   tway [ENTRIES];
  logic [CNT_W-1:0]   cnt  [ENTRIES];

  logic [IDX_W-1:0] free_idx, vic_idx, hit_idx;
  logic             hit_any;
  logic [ENTRIES-1:0] inv_match;

  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    hit_any  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
      if (vld[i] && tset[i] == hit_set && tway[i] == hit_way) begin
        hit_idx = IDX_W'(i);
        hit_any = 1'b1;
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] best;
    best    = cnt[0];
    vic_idx = '0;
    for (int i = 1; i < ENTRIES; i++)
      if (cnt[i] < best) begin
        best    = cnt[i];
        vic_idx = IDX_W'(i);
      end
  end

  always_comb
    for (int i = 0; i < ENTRIES; i++)
      inv_match[i] = vld[i] && tset[i] == inv_set && tway[i] == inv_way;

  wire full     = &vld;
  wire alloc    = wr_hit && !hit_dirty && !inv_req;
  wire bump     = wr_hit && hit_dirty && !inv_req && hit_any;
  wire age      = bump && cnt[hit_idx] == CNT_MAX;
  wire [IDX_W-1:0] slot = full ? vic_idx : free_idx;

  assign stall      = alloc && full && wbq_full;
  assign wbq_push   = alloc && full && !wbq_full;
  assign mark_dirty = alloc && !stall;
  assign wbq_set    = tset[vic_idx];
  assign wbq_way    = tway[vic_idx];

  wire rd_in = {1'b0, rd_idx} < (IDX_W+1)'(ENTRIES);
  assign rd_valid = rd_in && vld[rd_idx];
  assign rd_set   = tset[rd_idx];
  assign rd_way   = tway[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tset[i] <= '0;
        tway[i] <= '0;
        cnt[i]  <= '0;
      end
    end else if (inv_req) begin
      vld <= vld & ~inv_match;
    end else if (mark_dirty) begin
      vld[slot]  <= 1'b1;
      tset[slot] <= hit_set;
      tway[slot] <= hit_way;
      cnt[slot]  <= CNT_W'(1);
    end else if (age) begin
      for (int i = 0; i < ENTRIES; i++)
        if (IDX_W'(i) == hit_idx) cnt[i] <= CNT_MAX - HALF;
        else                      cnt[i] <= (cnt[i] >= HALF) ? cnt[i] - HALF : '0;
    end else if (bump) begin
      cnt[hit_idx] <= cnt[hit_idx] + CNT_W'(1);
    end
  end

  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_dirty && !wbq_push) |=> $countones(vld) == $past($countones(vld)) + 1);

  assert_push_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wbq_push |=> &vld);

  assert_stall_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(vld));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !inv_req) |=> $stable(vld));

  assert_dirty_hit_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && hit_dirty) |-> (!mark_dirty && !wbq_push));

  assert_inv_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req |-> (!mark_dirty && !stall && !wbq_push));
endmodule

// File: tb/sim_dirty_line_limiter.sv
`timescale 1ns/1ps
module sim_dirty_line_limiter;
  localparam int E = 12, SW = 6, WW = 2, IW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_hit = 0, hit_dirty = 0, inv_req = 0, wbq_full = 0;
  logic [SW-1:0] hit_set = 0, inv_set = 0;
  logic [WW-1:0] hit_way = 0, inv_way = 0;
  logic [IW-1:0] rd_idx = 0;
  logic mark_dirty, stall, wbq_push, rd_valid;
  logic [SW-1:0] wbq_set, rd_set;
  logic [WW-1:0] wbq_way, rd_way;

  always #10 clk = ~clk;

  dirty_line_limiter u0 (.clk, .rst_n, .wr_hit, .hit_set, .hit_way, .hit_dirty,
    .inv_req, .inv_set, .inv_way, .mark_dirty, .stall, .wbq_full, .wbq_push,
    .wbq_set, .wbq_way, .rd_idx, .rd_valid, .rd_set, .rd_way);

  int checks = 0, fails = 0;
  int m_v[E], m_s[E], m_w[E], m_c[E];
  bit l1d[256];
  string tag = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit wh, int s, int w, bit inv, int is_, int iw, bit wf, int ri);
    int vic, nvalid, slot, h;
    bit e_alloc, e_full, e_stall, e_push, e_mark;
    @(negedge clk);
    wr_hit = wh; hit_set = SW'(s); hit_way = WW'(w); hit_dirty = l1d[s*4+w];
    inv_req = inv; inv_set = SW'(is_); inv_way = WW'(iw); wbq_full = wf; rd_idx = IW'(ri);
    #2;
    nvalid = 0; vic = 0; slot = -1; h = -1;
    for (int j = 0; j < E; j++) begin
      nvalid += m_v[j];
      if (m_c[j] < m_c[vic]) vic = j;
      if (slot < 0 && !m_v[j]) slot = j;
      if (h < 0 && m_v[j] && m_s[j] == s && m_w[j] == w) h = j;
    end
    e_full  = (nvalid == E);
    e_alloc = wh && !l1d[s*4+w] && !inv;
    e_stall = e_alloc && e_full && wf;
    e_push  = e_alloc && e_full && !wf;
    e_mark  = e_alloc && !e_stall;
    chk("mark_dirty", mark_dirty, e_mark);
    chk("stall", stall, e_stall);
    chk("wbq_push", wbq_push, e_push);
    if (e_push) begin
      chk("wbq_set", wbq_set, m_s[vic]);
      chk("wbq_way", wbq_way, m_w[vic]);
    end
    chk("rd_valid", rd_valid, m_v[ri]);
    if (m_v[ri]) begin
      chk("rd_set", rd_set, m_s[ri]);
      chk("rd_way", rd_way, m_w[ri]);
    end
    @(posedge clk); #1;
    if (inv) begin
      for (int j = 0; j < E; j++)
        if (m_v[j] && m_s[j] == is_ && m_w[j] == iw) m_v[j] = 0;
      l1d[is_*4+iw] = 0;
    end else if (e_mark) begin
      if (e_full) begin slot = vic; l1d[m_s[vic]*4+m_w[vic]] = 0; end
      m_v[slot] = 1; m_s[slot] = s; m_w[slot] = w; m_c[slot] = 1;
      l1d[s*4+w] = 1;
    end else if (wh && l1d[s*4+w] && h >= 0) begin
      if (m_c[h] == 63)
        for (int j = 0; j < E; j++) m_c[j] = (j == h) ? 31 : (m_c[j] >= 32 ? m_c[j] - 32 : 0);
      else m_c[h]++;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < E; j++) begin m_v[j] = 0; m_s[j] = 0; m_w[j] = 0; m_c[j] = 0; end
    for (int j = 0; j < 256; j++) l1d[j] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    for (int k = 0; k < E; k++) cyc(0, 0, 0, 0, 0, 0, 0, k);
    tag = "R2";
    for (int k = 0; k < E; k++) cyc(1, k, k % 4, 0, 0, 0, 0, (k + E - 1) % E);
    tag = "R3";
    for (int k = 0; k < E; k++)
      for (int n = 0; n < ((k == 5) ? 1 : k + 2); n++) cyc(1, k, k % 4, 0, 0, 0, 0, k);
    tag = "R5";
    for (int n = 0; n < 3; n++) cyc(1, 20, 1, 0, 0, 0, 1, 5);
    tag = "R4";
    cyc(1, 20, 1, 0, 0, 0, 0, 5);
    cyc(0, 0, 0, 0, 0, 0, 0, 5);
    cyc(1, 21, 2, 0, 0, 0, 0, 5);
    tag = "R7";
    for (int k = 0; k < E; k++) cyc(0, 0, 0, 0, 0, 0, 0, k);
    tag = "R8";
    cyc(0, 0, 0, 1, 3, 3, 0, 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 3);
    cyc(1, 22, 0, 1, 4, 0, 0, 4);
    cyc(0, 0, 0, 0, 0, 0, 0, 4);
    cyc(1, 23, 1, 0, 0, 0, 0, 3);
    tag = "R6";
    for (int n = 0; n < 70; n++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 24, 2, 0, 0, 0, 0, 0);
    cyc(1, 25, 3, 0, 0, 0, 0, 1);
    for (int k = 0; k < E; k++) cyc(0, 0, 0, 0, 0, 0, 0, k);
    tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int s = $urandom_range(0, 15), w = $urandom_range(0, 3);
      if (r < 5) cyc(0, 0, 0, 1, s, w, 0, $urandom_range(0, E - 1));
      else if (r < 15) cyc(0, 0, 0, 0, 0, 0, 0, $urandom_range(0, E - 1));
      else if (r < 25) cyc(1, 0, 0, 0, 0, 0, $urandom_range(0, 1), $urandom_range(0, E - 1));
      else cyc(1, s, w, 0, 0, 0, ($urandom_range(0, 9) < 3), $urandom_range(0, E - 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule